// File: doc/BRIEF.md
# Grouped Interrupt Aggregator with Pending Latch

This block gathers many level-sensitive interrupt sources into a small number of request lines for a downstream interrupt controller. Sources are split into groups (nine groups of 32 lines by default). Each group owns one request line, a stored enable register, a status register and three hidden vectors: a sticky enable that only gains bits, a mask, and a pending set. When a group's sources show a new event, the enabled active lines are captured into status and the request line is raised. Firmware reads status to learn which sources fired, then clears status bits as each handler finishes.

While a group is busy, new events are not allowed to overwrite status. A group is busy when status is nonzero or when firmware has masked sources by rewriting the enable register with bits removed. Such events collect in the pending set. Once a status write drains status to zero, the pending set moves into status and the request line stays high. If nothing is pending, the line drops. The register port is a plain single-cycle word port with no handshake. Writes take effect at the clock edge. Read data is combinational from the stored registers.

Top module: `intagg_top`

## Requirements
- R1: After reset every request line is low, and every enable and status register reads zero.
- R2: For group n (0 to 8), the enable register sits at byte address 0x1000 + 0x100·n and the status register at 0x1004 + 0x100·n. The group index is address bits [11:8]. Every other address reads zero and ignores writes, and this includes indices 9 to 15.
- R3: A source event occurs when the OR of a group's raw lines goes from 0 to 1 between two clock samples. The event captures the active lines ANDed with the sticky enable. If the capture is nonzero and the group is idle (mask zero and status zero), status takes the capture and the request line is high from the next cycle on.
- R4: If a nonzero capture arrives while the mask or the status of its group is nonzero, it is ORed into the pending set and status keeps its value.
- R5: An enable write of zero while the sticky enable is zero only updates the stored value. Otherwise the sticky enable becomes old OR data. If that adds bits, the stored value takes the data and the mask is untouched.
- R6: An enable write that adds no sticky bits computes change = stored XOR data. If change AND data is nonzero, the changed bits are cleared from the mask. Otherwise they are set in the mask. The stored value then takes the data.
- R7: Status writes clear the bits written as one. A write of 0xFFFFFFFF only clears status: pending and the request line are left as they were.
- R8: Any other status write that leaves status at zero moves a nonzero pending set into status, empties pending and keeps the request line high. With pending empty, it lowers the request line.
- R9: Lines that stay high or fall produce no event. Only a fresh 0-to-1 of the group OR is an event.
- R10: Groups are independent. Events in several groups in the same cycle are all taken.
- R11: Reading an enable register returns the data last written there, not the sticky enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 13 | Byte address inside the 0x2000-byte window |
| reg_wr | input | 1 | Write strobe for one cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| src_lines | input | 288 | Source lines; group n uses bits [32n+31:32n] |
| irq_out | output | 9 | Request line per group |

## Verification
A wrong mask, sticky enable or pending set stays hidden until a later event or status drain exposes it. The symptom is a request line that does not rise on a capture, or a status value after replay that differs from the deferred sources. The tests therefore follow each hidden-state change with an event and a drain, and compare the request lines on every cycle and status on readback. A wrong capture shows up in status one cycle after the edge. A wrong drain shows up on the request line one cycle after the status write.

// File: rtl/intagg_pkg.sv
package intagg_pkg;
  // address layout of the group register area
  localparam int unsigned GRP_AREA_BASE = 32'h1000;
  localparam int unsigned GRP_STRIDE_LG = 8;
  localparam int unsigned STAT_OFFSET   = 4;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_EN   = 2'd1,
    ACC_STAT = 2'd2
  } acc_kind_e;
endpackage

// File: rtl/intagg_decode.sv
module intagg_decode
  import intagg_pkg::*;
#(
  parameter int unsigned NUM_GRP = 9,
  parameter int unsigned ADDR_W  = 13
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic [NUM_GRP-1:0] en_sel,
  output logic [NUM_GRP-1:0] st_sel
);
  localparam int unsigned GIDX_W = ADDR_W - GRP_STRIDE_LG;
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(GRP_AREA_BASE);

  logic [ADDR_W-1:0]        offs;
  logic [GIDX_W-1:0]        gidx;
  logic [GRP_STRIDE_LG-1:0] low;
  logic                     in_area;
  acc_kind_e                kind;

  always_comb begin
    in_area = (addr >= BASE_A);
    offs    = addr - BASE_A;
    gidx    = offs[ADDR_W-1:GRP_STRIDE_LG];
    low     = offs[GRP_STRIDE_LG-1:0];
    kind    = ACC_NONE;
    if (in_area && (gidx < GIDX_W'(NUM_GRP))) begin
      if (low == GRP_STRIDE_LG'(0))                kind = ACC_EN;
      else if (low == GRP_STRIDE_LG'(STAT_OFFSET)) kind = ACC_STAT;
    end
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_sel
    assign en_sel[g] = (kind == ACC_EN)   && (gidx == GIDX_W'(g));
    assign st_sel[g] = (kind == ACC_STAT) && (gidx == GIDX_W'(g));
  end

  // R2: at most one register selected by any address
  always_comb a_r2_one_select: assert ($onehot0({en_sel, st_sel}));
endmodule

// File: rtl/intagg_edge.sv
module intagg_edge #(
  parameter int unsigned LINES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] src,
  output logic             evt
);
  logic any_now;
  logic any_q;

  assign any_now = |src;
  assign evt     = any_now & ~any_q;

  always_ff @(posedge clk) begin
    if (!rst_n) any_q <= 1'b0;
    else        any_q <= any_now;
  end

  // R9: an event is a single-cycle pulse
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> !evt);
endmodule

// File: rtl/intagg_group.sv
module intagg_group #(
  parameter int unsigned LINES = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] src,
  input  logic             evt,
  input  logic             en_wr,
  input  logic             st_wr,
  input  logic [LINES-1:0] wdata,
  output logic [LINES-1:0] en_val,
  output logic [LINES-1:0] st_val,
  output logic             irq
);
  logic [LINES-1:0] en_q, sticky_q, mask_q, pend_q, stat_q;
  logic [LINES-1:0] en_n, sticky_n, mask_n, pend_n, stat_n;
  logic [LINES-1:0] chg, cap;
  logic             irq_q, irq_n;

  always_comb begin
    en_n     = en_q;
    sticky_n = sticky_q;
    mask_n   = mask_q;
    pend_n   = pend_q;
    stat_n   = stat_q;
    irq_n    = irq_q;
    chg      = '0;
    // register write first
    if (en_wr) begin
      if (wdata == '0 && sticky_q == '0) begin
        en_n = wdata;
      end else if ((sticky_q | wdata) != sticky_q) begin
        sticky_n = sticky_q | wdata;
        en_n     = wdata;
      end else begin
        chg = en_q ^ wdata;
        if ((chg & wdata) != '0) mask_n = mask_q & ~chg;
        else                     mask_n = mask_q | chg;
        en_n = wdata;
      end
    end
    if (st_wr) begin
      stat_n = stat_q & ~wdata;
      if (wdata != '1 && stat_n == '0) begin
        if (pend_q != '0) begin
          stat_n = pend_q;
          pend_n = '0;
          irq_n  = 1'b1;
        end else begin
          irq_n  = 1'b0;
        end
      end
    end
    // then the source event, seen against the post-write state
    cap = src & sticky_n;
    if (evt && cap != '0) begin
      if (mask_n != '0 || stat_n != '0) pend_n = pend_n | cap;
      else begin
        stat_n = cap;
        irq_n  = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q     <= '0;
      sticky_q <= '0;
      mask_q   <= '0;
      pend_q   <= '0;
      stat_q   <= '0;
      irq_q    <= 1'b0;
    end else begin
      en_q     <= en_n;
      sticky_q <= sticky_n;
      mask_q   <= mask_n;
      pend_q   <= pend_n;
      stat_q   <= stat_n;
      irq_q    <= irq_n;
    end
  end

  assign en_val = en_q;
  assign st_val = stat_q;
  assign irq    = irq_q;

  // R4: a nonzero status is only changed by a status write
  a_r4_status_held: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q != '0 && !st_wr) |=> stat_q == $past(stat_q));
  // R4: pending only gains bits unless a status write drains it
  a_r4_pending_grows: assert property (@(posedge clk) disable iff (!rst_n)
    !st_wr |=> (pend_q & $past(pend_q)) == $past(pend_q));
  // R5: sticky enable never loses a bit
  a_r5_sticky_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($past(sticky_q) & ~sticky_q) == '0);
  // R6: mask moves only on an enable write
  a_r6_mask_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !en_wr |=> $stable(mask_q));
  // R3: a request rises only with something in status
  a_r3_rise_has_status: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> stat_q != '0);
  // R8: a request falls only after a status write
  a_r8_fall_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_q) |-> $past(st_wr));
endmodule

// File: rtl/intagg_top.sv
module intagg_top
  import intagg_pkg::*;
#(
  parameter int unsigned NUM_GRP   = 9,
  parameter int unsigned LINES     = 32,
  parameter int unsigned WIN_BYTES = 32'h2000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [$clog2(WIN_BYTES)-1:0] reg_addr,
  input  logic                     reg_wr,
  input  logic [LINES-1:0]         reg_wdata,
  output logic [LINES-1:0]         reg_rdata,
  input  logic [NUM_GRP*LINES-1:0] src_lines,
  output logic [NUM_GRP-1:0]       irq_out
);
  localparam int unsigned ADDR_W = $clog2(WIN_BYTES);

  logic [NUM_GRP-1:0] en_sel, st_sel;
  logic [LINES-1:0]   en_val [NUM_GRP];
  logic [LINES-1:0]   st_val [NUM_GRP];

  intagg_decode #(.NUM_GRP(NUM_GRP), .ADDR_W(ADDR_W)) u_decode (
    .addr   (reg_addr),
    .en_sel (en_sel),
    .st_sel (st_sel)
  );

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
    logic evt;

    intagg_edge #(.LINES(LINES)) u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .src   (src_lines[g*LINES +: LINES]),
      .evt   (evt)
    );

    intagg_group #(.LINES(LINES)) u_group (
      .clk    (clk),
      .rst_n  (rst_n),
      .src    (src_lines[g*LINES +: LINES]),
      .evt    (evt),
      .en_wr  (reg_wr & en_sel[g]),
      .st_wr  (reg_wr & st_sel[g]),
      .wdata  (reg_wdata),
      .en_val (en_val[g]),
      .st_val (st_val[g]),
      .irq    (irq_out[g])
    );
  end

  always_comb begin
    reg_rdata = '0;
    for (int g = 0; g < NUM_GRP; g++) begin
      if (en_sel[g]) reg_rdata = reg_rdata | en_val[g];
      if (st_sel[g]) reg_rdata = reg_rdata | st_val[g];
    end
  end

  // R1: request lines low while in reset
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rst_n |=> irq_out == '0);
endmodule

// File: tb/intagg_top_bench.sv
module intagg_top_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NG = 9;
  localparam int NL = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [12:0]     reg_addr = '0;
  logic            reg_wr = 1'b0;
  logic [31:0]     reg_wdata = '0;
  logic [31:0]     reg_rdata;
  logic [NG*NL-1:0] src_lines = '0;
  logic [NG-1:0]   irq_out;

  intagg_top u_intagg_top (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .src_lines (src_lines),
    .irq_out   (irq_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  // bench reference state
  logic [31:0] m_en [NG];
  logic [31:0] m_sk [NG];
  logic [31:0] m_mk [NG];
  logic [31:0] m_pd [NG];
  logic [31:0] m_st [NG];
  logic        m_irq [NG];
  logic        m_prev [NG];
  logic [NG*NL-1:0] src_v = '0;

  function automatic logic [12:0] en_addr(int g);
    return 13'(32'h1000 + 32'h100 * g);
  endfunction

  function automatic logic [12:0] st_addr(int g);
    return 13'(32'h1004 + 32'h100 * g);
  endfunction

  function automatic logic [31:0] mdl_read(logic [12:0] a);
    for (int g = 0; g < NG; g++) begin
      if (a == en_addr(g)) return m_en[g];
      if (a == st_addr(g)) return m_st[g];
    end
    return 32'h0;
  endfunction

  task automatic mdl_reset();
    for (int g = 0; g < NG; g++) begin
      m_en[g] = '0; m_sk[g] = '0; m_mk[g] = '0; m_pd[g] = '0;
      m_st[g] = '0; m_irq[g] = 1'b0; m_prev[g] = 1'b0;
    end
  endtask

  task automatic mdl_step(logic wr, logic [12:0] a, logic [31:0] d, logic [NG*NL-1:0] s);
    for (int g = 0; g < NG; g++) begin
      logic [31:0] lines;
      logic [31:0] diff;
      logic [31:0] capt;
      logic rise;
      lines = s[g*NL +: NL];
      if (wr && a == en_addr(g)) begin
        if (d == 0 && m_sk[g] == 0) m_en[g] = d;
        else if ((m_sk[g] | d) != m_sk[g]) begin m_sk[g] = m_sk[g] | d; m_en[g] = d; end
        else begin
          diff = m_en[g] ^ d;
          if ((diff & d) != 0) m_mk[g] = m_mk[g] & ~diff;
          else m_mk[g] = m_mk[g] | diff;
          m_en[g] = d;
        end
      end
      if (wr && a == st_addr(g)) begin
        m_st[g] = m_st[g] & ~d;
        if (d != 32'hFFFF_FFFF && m_st[g] == 0) begin
          if (m_pd[g] != 0) begin m_st[g] = m_pd[g]; m_pd[g] = 0; m_irq[g] = 1'b1; end
          else m_irq[g] = 1'b0;
        end
      end
      rise = (lines != 0) && !m_prev[g];
      m_prev[g] = (lines != 0);
      capt = lines & m_sk[g];
      if (rise && capt != 0) begin
        if (m_mk[g] != 0 || m_st[g] != 0) m_pd[g] = m_pd[g] | capt;
        else begin m_st[g] = capt; m_irq[g] = 1'b1; end
      end
    end
  endtask

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mdl_irq();
    logic [31:0] v = '0;
    for (int g = 0; g < NG; g++) v[g] = m_irq[g];
    return v;
  endfunction

  // one clock: drive at the falling edge, compare request lines at the next one
  task automatic tick(logic wr, logic [12:0] a, logic [31:0] d);
    reg_wr = wr; reg_addr = a; reg_wdata = d; src_lines = src_v;
    mdl_step(wr, a, d, src_v);
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
    chk("R3 R8 R10 request lines", 32'(irq_out), mdl_irq());
  endtask

  task automatic rd(string tag, logic [12:0] a, logic [31:0] exp);
    reg_addr = a; reg_wr = 1'b0;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic set_src(int g, int bitn, logic v);
    src_v[g*NL + bitn] = v;
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    report();
  end

  initial begin
    mdl_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 irq after reset", 32'(irq_out), 32'h0);
    rd("R1 enable g0", en_addr(0), 32'h0);
    rd("R1 status g8", st_addr(8), 32'h0);

    // R5 zero write with empty sticky, then enabling
    tick(1'b1, en_addr(0), 32'h0);
    rd("R5 zero write", en_addr(0), 32'h0);
    tick(1'b1, en_addr(0), 32'h0000_00F0);
    rd("R5 enable stored", en_addr(0), 32'h0000_00F0);

    // R3 capture on rising edge
    set_src(0, 4, 1'b1); set_src(0, 0, 1'b1);
    tick(1'b0, '0, '0);
    chk("R3 irq g0 raised", 32'(irq_out[0]), 32'h1);
    rd("R3 status capture", st_addr(0), 32'h0000_0010);
    // R3 unenabled group does nothing
    set_src(1, 0, 1'b1);
    tick(1'b0, '0, '0);
    chk("R3 disabled group quiet", 32'(irq_out[1]), 32'h0);

    // R4 defer while status busy
    set_src(0, 4, 1'b0); set_src(0, 0, 1'b0);
    tick(1'b0, '0, '0);
    set_src(0, 5, 1'b1);
    tick(1'b0, '0, '0);
    rd("R4 status unchanged", st_addr(0), 32'h0000_0010);

    // R8 drain with replay, then drain to idle
    tick(1'b1, st_addr(0), 32'h0000_0010);
    rd("R8 replayed pending", st_addr(0), 32'h0000_0020);
    chk("R8 irq held", 32'(irq_out[0]), 32'h1);
    tick(1'b1, st_addr(0), 32'h0000_0020);
    rd("R8 status drained", st_addr(0), 32'h0);
    chk("R8 irq low", 32'(irq_out[0]), 32'h0);

    // R9 lines held high or falling cause nothing
    tick(1'b0, '0, '0);
    set_src(0, 5, 1'b0);
    tick(1'b0, '0, '0);
    rd("R9 no event", st_addr(0), 32'h0);

    // R7 all-ones write is initialisation only
    set_src(0, 6, 1'b1);
    tick(1'b0, '0, '0);
    tick(1'b1, st_addr(0), 32'hFFFF_FFFF);
    rd("R7 status cleared", st_addr(0), 32'h0);
    chk("R7 irq kept", 32'(irq_out[0]), 32'h1);
    tick(1'b1, st_addr(0), 32'h0);
    chk("R8 empty pending lowers", 32'(irq_out[0]), 32'h0);
    set_src(0, 6, 1'b0);
    tick(1'b0, '0, '0);

    // R6 mask via removed enable bit, R11 readback
    tick(1'b1, en_addr(0), 32'h0000_0070);
    rd("R11 enable readback", en_addr(0), 32'h0000_0070);
    set_src(0, 4, 1'b1);
    tick(1'b0, '0, '0);
    chk("R6 masked no irq", 32'(irq_out[0]), 32'h0);
    rd("R6 masked status", st_addr(0), 32'h0);
    tick(1'b1, en_addr(0), 32'h0000_00F0);
    chk("R6 unmask no irq", 32'(irq_out[0]), 32'h0);
    tick(1'b1, st_addr(0), 32'h0);
    rd("R6 deferred replay", st_addr(0), 32'h0000_0010);
    tick(1'b1, st_addr(0), 32'h0000_0010);
    set_src(0, 4, 1'b0);
    tick(1'b0, '0, '0);

    // R2 unmapped addresses
    tick(1'b1, 13'h1900, 32'hFFFF_FFFF);
    rd("R2 group 9 enable", 13'h1900, 32'h0);
    tick(1'b1, 13'h0100, 32'h1234_5678);
    rd("R2 low address", 13'h0100, 32'h0);
    rd("R2 gap address", 13'h1008, 32'h0);

    // R10 simultaneous events in two groups
    tick(1'b1, en_addr(2), 32'h0000_0003);
    tick(1'b1, en_addr(8), 32'h8000_0000);
    set_src(2, 1, 1'b1); set_src(8, 31, 1'b1);
    tick(1'b0, '0, '0);
    chk("R10 both raised", 32'({irq_out[8], irq_out[2]}), 32'h3);
    rd("R10 group 8 status", st_addr(8), 32'h8000_0000);

    // random phase against the bench reference
    void'($urandom(32'd20240603));
    for (int i = 0; i < 4000; i++) begin
      int g;
      int r;
      logic [31:0] d;
      logic [12:0] a;
      g = int'($urandom_range(0, NG - 1));
      r = int'($urandom_range(0, 9));
      if ($urandom_range(0, 2) == 0)
        set_src(g, int'($urandom_range(0, 7)), 1'($urandom_range(0, 1)));
      if (r < 2) begin
        d = ($urandom_range(0, 4) == 0) ? 32'h0 : ($urandom & 32'h0000_00FF);
        a = en_addr(g);
        tick(1'b1, a, d);
      end else if (r < 4) begin
        case ($urandom_range(0, 5))
          0: d = 32'hFFFF_FFFF;
          1: d = 32'h0;
          2: d = $urandom;
          default: d = m_st[g] & (32'h1 << $urandom_range(0, 7));
        endcase
        a = st_addr(g);
        tick(1'b1, a, d);
      end else if (r == 4) begin
        tick(1'b1, 13'($urandom_range(0, 8191)), $urandom);
      end else begin
        tick(1'b0, '0, '0);
      end
      a = ($urandom_range(0, 1) == 0) ? en_addr(g) : st_addr(g);
      rd("R3 R4 R6 R8 random readback", a, mdl_read(a));
    end
    report();
  end
endmodule